// File: doc/BRIEF.md
# Shared Status Flag Bus Arbiter

This block is the per-device controller for a narrow bus that carries one status bit per queue. Several devices sit on the same wires, and at most one of them may drive those wires in any clock cycle. Each device presents its four queue status bits together with a per-bit output enable. A device that is not driving holds every enable low and its data at zero.

The arbitration scheme is fixed while master reset is held.

- **Addressed mode:** a shared address and strobe name the device that drives next. The change of driver takes effect one clock later.
- **Polled mode:** a token travels around a ring of devices. Each device that holds the token drives the bus for one cycle. The designated master device starts the rotation on the first edge after reset and raises a sync pulse each time it holds the token.

The controller is a five-state machine.

| State | Meaning |
|---|---|
| ST_BOOT | Reset and the first cycle after it. The device never drives here. |
| ST_ADDR_IDLE | Addressed mode, not driving. |
| ST_ADDR_DRIVE | Addressed mode, driving. |
| ST_POLL_WAIT | Polled mode, without the token. |
| ST_POLL_DRIVE | Polled mode, holding the token. |

Transitions:

- **boot_to_addr:** ST_BOOT goes to ST_ADDR_DRIVE on a matching strobe, and to ST_ADDR_IDLE otherwise.
- **boot_to_poll:** ST_BOOT goes to ST_POLL_DRIVE when the device is the master or the token input is high, and to ST_POLL_WAIT otherwise.
- **addr_claim:** ST_ADDR_IDLE goes to ST_ADDR_DRIVE on a strobe whose address field equals the device ID.
- **addr_release:** ST_ADDR_DRIVE goes to ST_ADDR_IDLE on a strobe that names another device.
- **tok_take:** ST_POLL_WAIT goes to ST_POLL_DRIVE when the token input is high.
- **tok_pass:** ST_POLL_DRIVE goes to ST_POLL_WAIT when the token input is low.

Top module: `stsbus_arb`

## Requirements
- R1: While reset is low, and in the first cycle after reset when no claim or token applies, `bus_oe` is 4'b0000, and `tok_out` and `sync_pulse` are low.
- R2: The arbitration mode is the value of `arb_mode` sampled while reset is low: 0 selects addressed mode and 1 selects polled mode. Changing `arb_mode` after reset has no effect on behaviour.
- R3: In addressed mode, a rising edge with `sel_strobe` high and `sel_addr[4:2]` equal to `dev_id` makes the device drive from the next cycle onward. Claims on consecutive cycles are honoured.
- R4: In addressed mode, a rising edge with `sel_strobe` high and `sel_addr[4:2]` not equal to `dev_id` stops the device driving from the next cycle.
- R5: In addressed mode, an edge with `sel_strobe` low leaves the driving state unchanged, whatever the value of `sel_addr`.
- R6: While driving, `bus_oe` is 4'b1111 and `bus_data[i]` equals `q_status[i]`, so queue 1 through queue 4 map to bits 0 through 3. While not driving, `bus_oe` and `bus_data` are 0.
- R7: In polled mode, the device with `ring_master` high drives in the cycle that follows the first rising edge after reset is released.
- R8: In polled mode, a device drives in the cycle after an edge at which `tok_in` is high, and only then. `tok_out` is high exactly in the cycles in which the device drives.
- R9: `sync_pulse` is high exactly in the cycles in which a polled-mode device with `ring_master` high drives. It is never high in addressed mode.
- R10: In addressed mode, `tok_out` stays low and `tok_in` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset, asynchronous to the state machine |
| arb_mode | input | 1 | Mode, sampled during reset: 0 addressed, 1 polled |
| ring_master | input | 1 | High on the one device that starts the token ring |
| dev_id | input | 3 | Identity of this device |
| sel_addr | input | 5 | Shared address; bits [4:2] name a device |
| sel_strobe | input | 1 | Qualifies `sel_addr` as a bus selection |
| tok_in | input | 1 | Token from the previous device in the ring |
| q_status | input | 4 | Per-queue status; bit i belongs to queue i+1 |
| bus_data | output | 4 | Status data presented to the shared bus |
| bus_oe | output | 4 | Per-bit drive enable for `bus_data` |
| tok_out | output | 1 | Token to the next device; high while driving in polled mode |
| sync_pulse | output | 1 | High while the ring master drives |

## Verification
The bench wires eight devices with IDs 0 through 7 onto one shared bus and one ring. It checks every cycle that the expected device is the only one enabled, and that the value resolved on the bus is that device's status.

- **Addressed sweep:** the strobe and address patterns include repeated claims, claims on back-to-back cycles and address changes with the strobe low. Two faults show up here: a latch that also updates without a strobe, and a latch that ignores a claim immediately after another claim. Either one leaves the wrong device enabled, or two devices enabled at once.
- **Polled runs:** two different devices act as ring master. An off-by-one start, or a token that lingers for two cycles, shifts the expected rotation or duplicates a driver.
- **Mode pin toggles:** the mode pin is flipped after reset in both modes. A design that reads the pin live would rotate while in addressed mode, or freeze while in polled mode.

// File: rtl/stsbus_pkg.sv
package stsbus_pkg;

    typedef enum logic [2:0] {
        ST_BOOT       = 3'd0,
        ST_ADDR_IDLE  = 3'd1,
        ST_ADDR_DRIVE = 3'd2,
        ST_POLL_WAIT  = 3'd3,
        ST_POLL_DRIVE = 3'd4
    } arb_state_e;

    localparam logic MODE_ADDRESSED = 1'b0;
    localparam logic MODE_POLLED    = 1'b1;

endpackage

// File: rtl/stsbus_mode_latch.sv
module stsbus_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic arb_mode,
    output logic poll_mode
);

    logic mode_q;

    // The mode is captured on every clock while reset is held and frozen afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= arb_mode;
        end
    end

    assign poll_mode = mode_q;

endmodule

// File: rtl/stsbus_addr_match.sv
module stsbus_addr_match #(
    parameter int ID_W   = 3,
    parameter int ADDR_W = 5
) (
    input  logic [ID_W-1:0]   dev_id,
    input  logic [ADDR_W-1:0] sel_addr,
    input  logic              sel_strobe,
    output logic              hit,
    output logic              miss
);

    localparam int FIELD_LSB = ADDR_W - ID_W;

    logic [ID_W-1:0] field;
    logic            same;

    assign field = sel_addr[ADDR_W-1:FIELD_LSB];
    assign same  = (field == dev_id);
    assign hit   = sel_strobe && same;
    assign miss  = sel_strobe && !same;

endmodule

// File: rtl/stsbus_fsm.sv
module stsbus_fsm
    import stsbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic poll_mode,
    input  logic ring_master,
    input  logic tok_in,
    input  logic hit,
    input  logic miss,
    output logic drive,
    output logic tok_out,
    output logic sync_pulse
);

    arb_state_e state_q;
    arb_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: begin
                if (poll_mode == MODE_POLLED) begin
                    state_d = (ring_master || tok_in) ? ST_POLL_DRIVE : ST_POLL_WAIT;
                end else begin
                    state_d = hit ? ST_ADDR_DRIVE : ST_ADDR_IDLE;
                end
            end
            ST_ADDR_IDLE: begin
                if (hit) begin
                    state_d = ST_ADDR_DRIVE;
                end
            end
            ST_ADDR_DRIVE: begin
                if (miss) begin
                    state_d = ST_ADDR_IDLE;
                end
            end
            ST_POLL_WAIT: begin
                if (tok_in) begin
                    state_d = ST_POLL_DRIVE;
                end
            end
            ST_POLL_DRIVE: begin
                if (!tok_in) begin
                    state_d = ST_POLL_WAIT;
                end
            end
            default: state_d = ST_BOOT;
        endcase
    end

    always_comb begin
        drive      = 1'b0;
        tok_out    = 1'b0;
        sync_pulse = 1'b0;
        unique case (state_q)
            ST_BOOT, ST_ADDR_IDLE, ST_POLL_WAIT: begin
                drive = 1'b0;
            end
            ST_ADDR_DRIVE: begin
                drive = 1'b1;
            end
            ST_POLL_DRIVE: begin
                drive      = 1'b1;
                tok_out    = 1'b1;
                sync_pulse = ring_master;
            end
            default: drive = 1'b0;
        endcase
    end

endmodule

// File: rtl/stsbus_drive.sv
module stsbus_drive #(
    parameter int NQ = 4
) (
    input  logic          drive,
    input  logic [NQ-1:0] q_status,
    output logic [NQ-1:0] bus_data,
    output logic [NQ-1:0] bus_oe
);

    for (genvar i = 0; i < NQ; i++) begin : gen_bit
        assign bus_data[i] = drive & q_status[i];
        assign bus_oe[i]   = drive;
    end

endmodule

// File: rtl/stsbus_arb.sv
module stsbus_arb #(
    parameter int NQ     = 4,
    parameter int ID_W   = 3,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arb_mode,
    input  logic              ring_master,
    input  logic [ID_W-1:0]   dev_id,
    input  logic [ADDR_W-1:0] sel_addr,
    input  logic              sel_strobe,
    input  logic              tok_in,
    input  logic [NQ-1:0]     q_status,
    output logic [NQ-1:0]     bus_data,
    output logic [NQ-1:0]     bus_oe,
    output logic              tok_out,
    output logic              sync_pulse
);

    logic poll_mode_q;
    logic hit;
    logic miss;
    logic drive;

    stsbus_mode_latch u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .arb_mode  (arb_mode),
        .poll_mode (poll_mode_q)
    );

    stsbus_addr_match #(
        .ID_W   (ID_W),
        .ADDR_W (ADDR_W)
    ) u_match (
        .dev_id     (dev_id),
        .sel_addr   (sel_addr),
        .sel_strobe (sel_strobe),
        .hit        (hit),
        .miss       (miss)
    );

    stsbus_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .poll_mode   (poll_mode_q),
        .ring_master (ring_master),
        .tok_in      (tok_in),
        .hit         (hit),
        .miss        (miss),
        .drive       (drive),
        .tok_out     (tok_out),
        .sync_pulse  (sync_pulse)
    );

    stsbus_drive #(
        .NQ (NQ)
    ) u_drive (
        .drive    (drive),
        .q_status (q_status),
        .bus_data (bus_data),
        .bus_oe   (bus_oe)
    );

endmodule

// File: rtl/stsbus_arb_chk.sv
module stsbus_arb_chk #(
    parameter int NQ     = 4,
    parameter int ID_W   = 3,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              poll_mode,
    input logic              ring_master,
    input logic [ID_W-1:0]   dev_id,
    input logic [ADDR_W-1:0] sel_addr,
    input logic              sel_strobe,
    input logic              tok_in,
    input logic [NQ-1:0]     q_status,
    input logic [NQ-1:0]     bus_data,
    input logic [NQ-1:0]     bus_oe,
    input logic              tok_out,
    input logic              sync_pulse
);

    localparam int FIELD_LSB = ADDR_W - ID_W;

    logic [ID_W-1:0] field;
    assign field = sel_addr[ADDR_W-1:FIELD_LSB];

    p_addr_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!poll_mode && sel_strobe && field == dev_id) |=> (bus_oe == {NQ{1'b1}}));

    p_addr_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!poll_mode && sel_strobe && field != dev_id) |=> (bus_oe == '0));

    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!poll_mode && !sel_strobe) |=> $stable(bus_oe));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe == '0) |-> (bus_data == '0));

    p_data_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe == {NQ{1'b1}}) |-> (bus_data == q_status));

    p_token_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_mode && tok_in) |=> tok_out);

    p_token_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |-> (bus_oe == {NQ{1'b1}}));

    p_sync_master_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> (ring_master && tok_out && poll_mode));

    p_addr_no_token_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_mode |-> !tok_out);

endmodule

bind stsbus_arb stsbus_arb_chk #(
    .NQ     (NQ),
    .ID_W   (ID_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_mode   (poll_mode_q),
    .ring_master (ring_master),
    .dev_id      (dev_id),
    .sel_addr    (sel_addr),
    .sel_strobe  (sel_strobe),
    .tok_in      (tok_in),
    .q_status    (q_status),
    .bus_data    (bus_data),
    .bus_oe      (bus_oe),
    .tok_out     (tok_out),
    .sync_pulse  (sync_pulse)
);

// File: tb/stsbus_arb_tb_top.sv
`timescale 1ns/1ps
module stsbus_arb_tb_top;

    localparam int ND = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         arb_mode = 1'b0;
    logic [ND-1:0] mast = '0;
    logic [4:0]   sel_addr = '0;
    logic         sel_strobe = 1'b0;
    logic [3:0]   qs  [ND];
    logic [3:0]   bd  [ND];
    logic [3:0]   oe  [ND];
    logic [ND-1:0] tok;
    logic [ND-1:0] syn;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    for (genvar g = 0; g < ND; g++) begin : gen_dev
        stsbus_arb dut_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .arb_mode    (arb_mode),
            .ring_master (mast[g]),
            .dev_id      (3'(g)),
            .sel_addr    (sel_addr),
            .sel_strobe  (sel_strobe),
            .tok_in      (tok[(g + ND - 1) % ND]),
            .q_status    (qs[g]),
            .bus_data    (bd[g]),
            .bus_oe      (oe[g]),
            .tok_out     (tok[g]),
            .sync_pulse  (syn[g])
        );
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_status();
        for (int d = 0; d < ND; d++) qs[d] = 4'((d * 3 + cyc * 5) & 15);
        cyc++;
    endtask

    // owner: expected driver, -1 for none; polled selects token/sync expectations
    task automatic check_bus(input int owner, input bit polled, input int master, input string req);
        int  nen;
        logic [3:0] res;
        nen = 0;
        res = '0;
        for (int d = 0; d < ND; d++) begin
            int exp_oe;
            exp_oe = (d == owner) ? 15 : 0;
            chk(oe[d] == 4'(exp_oe), req, int'(oe[d]), exp_oe);
            if (oe[d] != 0) nen++;
            res = res | (bd[d] & oe[d]);
            if (d != owner) chk(bd[d] == 4'b0, "R6 idle data", int'(bd[d]), 0);
            chk(tok[d] == (polled && d == owner), polled ? "R8 token" : "R10 token",
                int'(tok[d]), int'(polled && d == owner));
            chk(syn[d] == (polled && d == owner && d == master), "R9 sync",
                int'(syn[d]), int'(polled && d == owner && d == master));
        end
        chk(nen == (owner >= 0 ? 1 : 0), "R6 single driver", nen, owner >= 0 ? 1 : 0);
        if (owner >= 0) chk(res == qs[owner], "R6 bus value", int'(res), int'(qs[owner]));
    endtask

    task automatic do_reset(input bit mode, input int master);
        @(negedge clk);
        rst_n = 1'b0;
        arb_mode = mode;
        mast = '0;
        if (master >= 0) mast[master] = 1'b1;
        sel_strobe = 1'b0;
        set_status();
        repeat (3) @(negedge clk);
        check_bus(-1, 1'b0, -1, "R1 reset");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int owner;
        // ---- addressed mode sweep: R1 R2 R3 R4 R5 R6 R10
        do_reset(1'b0, 3);
        owner = -1;
        for (int c = 0; c < 240; c++) begin
            @(negedge clk);
            check_bus(owner, 1'b0, 3, c == 0 ? "R1 first cycle" : "R3/R4/R5 owner");
            if (c == 120) arb_mode = 1'b1;       // R2: ignored after reset
            sel_strobe = ((c % 4) != 3) && ((c / 40) % 2 == 0 || (c % 7) == 0);
            sel_addr   = {3'((c * 5 + c / 9) % ND), 2'(c)};
            if (sel_strobe) owner = int'(sel_addr[4:2]);
            set_status();
        end
        // ---- polled mode with two different masters: R7 R8 R9 R2
        for (int m = 0; m < 2; m++) begin
            int master;
            master = (m == 0) ? 0 : 5;
            do_reset(1'b1, master);
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                check_bus((master + k) % ND, 1'b1, master, k == 0 ? "R7 master start" : "R8 rotation");
                if (k == 10) arb_mode = 1'b0;    // R2: ignored after reset
                sel_strobe = (k > 10);
                sel_addr   = 5'(k * 7);
                set_status();
            end
            arb_mode = 1'b1;
        end
        // ---- addressed mode again, claims on every cycle: R3
        do_reset(1'b0, -1);
        owner = -1;
        for (int c = 0; c < 32; c++) begin
            @(negedge clk);
            check_bus(owner, 1'b0, -1, "R3 back-to-back claims");
            sel_strobe = 1'b1;
            sel_addr   = {3'(ND - 1 - (c % ND)), 2'(c + 1)};
            owner      = int'(sel_addr[4:2]);
            set_status();
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule